// File: doc/BRIEF.md
# Quadrature and Count-Input Decoder

This block sits in front of a 24-bit up/down counter core. It turns two external count inputs into single-cycle increment and decrement requests and a direction flag. The inputs can be read in three ways. As separate up and down clocks. As a clock with a direction level. As a quadrature pair decoded at one, two or four counts per cycle, where a stability filter screens each input. The block does no counter arithmetic of its own.

Two active-low auxiliary pins are handled here as well. The first is a dual-function pin that either clears the counter or gates counting. The second is a load pin that requests either a counter load from the preset or a capture of the counter into the output latch. Configuration arrives as two register writes on a shared 6-bit data input. The input-control word also carries one-shot software increment and decrement commands.

Top module: `qdec_count_front`

## Requirements
- R1: With input-control bit0 = 0 and quadrature off, a rising edge on A gives one pulse on `cnt_up_o`, and a rising edge on B gives one pulse on `cnt_dn_o`. Rising edges on both inputs in the same cycle cancel, so no pulse is given.
- R2: With input-control bit0 = 1 and quadrature off, each rising edge of A counts once. It counts up while B is low and down while B is high. Edges on B never count.
- R3: With the quadrature field (bits 1:0 of the quadrature word) = 11, every accepted change of exactly one input gives one pulse. Stepping A,B through 00, 10, 11, 01 (A leading B) counts up, and the reverse order counts down.
- R4: With the quadrature field = 10, only accepted changes of A count. The direction is decided as in R3, and changes of B alone give no pulse.
- R5: With the quadrature field = 01, only a change of A while B is low counts. A rising edge counts up and a falling edge counts down, giving one count per full cycle.
- R6: In quadrature mode, when both inputs change in the same accepted step, no pulse is given.
- R7: In quadrature mode, a change on an input is accepted only after the synchronized level has differed from the accepted level for FILT_CYCLES consecutive cycles (default 4). A shorter glitch gives no count.
- R8: `dir_up_o` resets to 1. In quadrature mode it becomes 1 after an up count and 0 after a down count. With the quadrature field = 00 it is forced to 1.
- R9: While input-control bit3 (input enable) is 0, no count pulses are given, whatever the inputs or the step commands do.
- R10: With input-control bit4 = 0, a low level on `pin_dual_n` asserts `ctr_clear_o`. With bit4 = 1, `ctr_clear_o` stays low and the pin gates the inputs: a high level blocks hardware counts and a low level lets them through.
- R11: A low level on `pin_load_n` asserts `ctr_load_o` when input-control bit5 = 0, and asserts `latch_load_o` when bit5 = 1.
- R12: A write of the input-control word with bit3 = 1 and bit1 = 1 gives exactly one up pulse. With bit3 = 1 and bit2 = 1 it gives exactly one down pulse. With both bit1 and bit2 set, or with bit3 = 0, it gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icr_wr | input | 1 | Write strobe for the input-control word |
| qr_wr | input | 1 | Write strobe for the quadrature word |
| wr_data | input | 6 | Write data shared by both control words |
| in_a | input | 1 | Asynchronous count input A |
| in_b | input | 1 | Asynchronous count input B |
| pin_dual_n | input | 1 | Active-low clear-or-gate pin |
| pin_load_n | input | 1 | Active-low load pin |
| cnt_up_o | output | 1 | Single-cycle increment request |
| cnt_dn_o | output | 1 | Single-cycle decrement request |
| dir_up_o | output | 1 | Direction flag, 1 = up |
| ctr_clear_o | output | 1 | Counter clear request (level) |
| ctr_load_o | output | 1 | Counter load-from-preset request (level) |
| latch_load_o | output | 1 | Latch capture request (level) |

## Verification
The assertions assume the following about the inputs:
- A and B move one level at a time and are held longer than the filter window, except in the deliberate glitch and both-change steps.
- Configuration writes happen while the inputs are idle, so a mode switch never meets a half-finished edge.
- `pin_dual_n` changes only while A and B are quiet.

The stimulus keeps to these rules. Every input change is held for twelve cycles, and every mode change is made with A and B at rest at 00. Pin levels are set and given time to pass their synchronizers before any count edge is driven.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        QM_OFF = 2'b00,
        QM_X1  = 2'b01,
        QM_X2  = 2'b10,
        QM_X4  = 2'b11
    } qmode_e;

    // bit positions inside the input-control word
    localparam int unsigned IC_CLKDIR  = 0;
    localparam int unsigned IC_STEP_UP = 1;
    localparam int unsigned IC_STEP_DN = 2;
    localparam int unsigned IC_EN      = 3;
    localparam int unsigned IC_PINGATE = 4;
    localparam int unsigned IC_LATCH   = 5;

    typedef struct packed {
        logic latch_sel;  // load pin captures latch instead of loading counter
        logic pin_gate;   // dual pin gates inputs instead of clearing
        logic in_en;      // A/B inputs enabled
        logic clk_dir;    // A = clock, B = direction
    } in_cfg_t;

    typedef struct packed {
        logic up;
        logic dn;
    } cnt_ev_t;

endpackage

// File: rtl/qdec_sync2.sv
module qdec_sync2 #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {2{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[1];

endmodule

// File: rtl/qdec_in_filter.sv
module qdec_in_filter #(
    parameter int unsigned FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic filt_o
);

    localparam int unsigned CW   = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    qdec_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_i),
        .sync_o  (sync_o)
    );

    always_comb begin
        flt_d = flt_q;
        if (sync_o == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == LAST) begin
            flt_d.lvl = sync_o;
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign filt_o = flt_q.lvl;

    // R7: the accepted level only moves after the full stability window
    p_filter_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.lvl != $past(flt_q.lvl)) |-> ($past(flt_q.cnt) == LAST && $past(sync_o) == flt_q.lvl));

endmodule

// File: rtl/qdec_quad.sv
module qdec_quad
    import qdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  qmode_e  mode_i,
    input  logic    a_i,
    input  logic    b_i,
    output cnt_ev_t ev_o
);

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    ab_t  prev_d, prev_q;
    logic ch_a, ch_b, fwd, hit;

    always_comb begin
        prev_d = '{a: a_i, b: b_i};
        ch_a   = a_i ^ prev_q.a;
        ch_b   = b_i ^ prev_q.b;
        // A leading B: new A differs from old B on a forward step
        fwd    = a_i ^ prev_q.b;
        unique case (mode_i)
            QM_X4:   hit = ch_a ^ ch_b;
            QM_X2:   hit = ch_a & ~ch_b;
            QM_X1:   hit = ch_a & ~ch_b & ~b_i;
            default: hit = 1'b0;
        endcase
        ev_o.up = hit & fwd;
        ev_o.dn = hit & ~fwd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R6: simultaneous change of both inputs never counts
    p_illegal_nocount_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i != $past(a_i) && b_i != $past(b_i)) |-> (!ev_o.up && !ev_o.dn));

    // R4: in x2 a change of B alone is silent
    p_x2_b_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_X2 && a_i == $past(a_i)) |-> (!ev_o.up && !ev_o.dn));

endmodule

// File: rtl/qdec_count_front.sv
module qdec_count_front
    import qdec_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       icr_wr,
    input  logic       qr_wr,
    input  logic [5:0] wr_data,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       pin_dual_n,
    input  logic       pin_load_n,
    output logic       cnt_up_o,
    output logic       cnt_dn_o,
    output logic       dir_up_o,
    output logic       ctr_clear_o,
    output logic       ctr_load_o,
    output logic       latch_load_o
);

    localparam int unsigned NUM_IN  = 2;  // index 1 = A, 0 = B
    localparam int unsigned NUM_PIN = 2;  // index 1 = dual pin, 0 = load pin

    typedef struct packed {
        in_cfg_t    cfg;
        qmode_e     qmode;
        logic       step_up;
        logic       step_dn;
        logic       up;
        logic       dn;
        logic       dir;
        logic [1:0] prev_raw;
    } st_t;

    localparam st_t ST_RST = '{
        cfg: '0, qmode: QM_OFF, step_up: 1'b0, step_dn: 1'b0,
        up: 1'b0, dn: 1'b0, dir: 1'b1, prev_raw: 2'b00
    };

    st_t st_d, st_q;

    logic [NUM_IN-1:0]  raw_ab, sync_ab, filt_ab;
    logic [NUM_PIN-1:0] raw_pin, sync_pin;
    cnt_ev_t            quad_ev, hw_ev;
    logic               rise_a, rise_b, gate_ok, up_c, dn_c;

    assign raw_ab  = {in_a, in_b};
    assign raw_pin = {pin_dual_n, pin_load_n};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ab
        qdec_in_filter #(.FILT_CYCLES(FILT_CYCLES)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_ab[i]),
            .sync_o (sync_ab[i]),
            .filt_o (filt_ab[i])
        );
    end

    for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
        qdec_sync2 #(.RST_VAL(1'b1)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_pin[i]),
            .sync_o  (sync_pin[i])
        );
    end

    qdec_quad u_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (st_q.qmode),
        .a_i    (filt_ab[1]),
        .b_i    (filt_ab[0]),
        .ev_o   (quad_ev)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prev_raw = sync_ab;

        // hardware count events from the selected input reading
        rise_a = sync_ab[1] & ~st_q.prev_raw[1];
        rise_b = sync_ab[0] & ~st_q.prev_raw[0];
        if (st_q.qmode != QM_OFF) begin
            hw_ev = quad_ev;
        end else if (st_q.cfg.clk_dir) begin
            hw_ev.up = rise_a & ~sync_ab[0];
            hw_ev.dn = rise_a & sync_ab[0];
        end else begin
            hw_ev.up = rise_a;
            hw_ev.dn = rise_b;
        end
        gate_ok = ~st_q.cfg.pin_gate | ~sync_pin[1];
        if (!(st_q.cfg.in_en && gate_ok)) hw_ev = '0;

        up_c = hw_ev.up;
        dn_c = hw_ev.dn;

        // pending software steps: a paired request cancels, hardware wins the slot
        if (st_q.step_up && st_q.step_dn) begin
            st_d.step_up = 1'b0;
            st_d.step_dn = 1'b0;
        end else if (!st_q.cfg.in_en) begin
            st_d.step_up = 1'b0;
            st_d.step_dn = 1'b0;
        end else if (!hw_ev.up && !hw_ev.dn) begin
            if (st_q.step_up) begin
                up_c         = 1'b1;
                st_d.step_up = 1'b0;
            end
            if (st_q.step_dn) begin
                dn_c         = 1'b1;
                st_d.step_dn = 1'b0;
            end
        end

        if (up_c && dn_c) begin
            up_c = 1'b0;
            dn_c = 1'b0;
        end
        st_d.up = up_c;
        st_d.dn = dn_c;

        // direction flag
        if (st_q.qmode == QM_OFF) st_d.dir = 1'b1;
        else if (hw_ev.up)        st_d.dir = 1'b1;
        else if (hw_ev.dn)        st_d.dir = 1'b0;

        // register writes
        if (icr_wr) begin
            st_d.cfg.clk_dir   = wr_data[IC_CLKDIR];
            st_d.cfg.in_en     = wr_data[IC_EN];
            st_d.cfg.pin_gate  = wr_data[IC_PINGATE];
            st_d.cfg.latch_sel = wr_data[IC_LATCH];
            if (wr_data[IC_EN]) begin
                st_d.step_up = st_d.step_up | wr_data[IC_STEP_UP];
                st_d.step_dn = st_d.step_dn | wr_data[IC_STEP_DN];
            end
        end
        if (qr_wr) st_d.qmode = qmode_e'(wr_data[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign cnt_up_o     = st_q.up;
    assign cnt_dn_o     = st_q.dn;
    assign dir_up_o     = st_q.dir;
    assign ctr_clear_o  = ~sync_pin[1] & ~st_q.cfg.pin_gate;
    assign ctr_load_o   = ~sync_pin[0] & ~st_q.cfg.latch_sel;
    assign latch_load_o = ~sync_pin[0] & st_q.cfg.latch_sel;

    // R1: an up and a down request never leave in the same cycle
    p_one_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up_o && cnt_dn_o));

    // R9: disabled inputs give no pulse in the following cycle
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.in_en |=> (!cnt_up_o && !cnt_dn_o));

    // R8: direction flag held at up while quadrature is off
    p_dir_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.qmode == QM_OFF) |=> dir_up_o);

    // R10: a closed gate blocks hardware counts
    p_gate_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.pin_gate && sync_pin[1] && !st_q.step_up && !st_q.step_dn)
            |=> (!cnt_up_o && !cnt_dn_o));

    // R2: in clock/direction mode nothing counts without a rising A
    p_clkdir_needs_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.qmode == QM_OFF && st_q.cfg.clk_dir && !(sync_ab[1] && !st_q.prev_raw[1])
            && !st_q.step_up && !st_q.step_dn) |=> (!cnt_up_o && !cnt_dn_o));

endmodule

// File: tb/tb_qdec_count_front.sv
module tb_qdec_count_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       icr_wr = 1'b0;
    logic       qr_wr = 1'b0;
    logic [5:0] wr_data = '0;
    logic       in_a = 1'b0;
    logic       in_b = 1'b0;
    logic       pin_dual_n = 1'b1;
    logic       pin_load_n = 1'b1;
    logic       cnt_up_o, cnt_dn_o, dir_up_o, ctr_clear_o, ctr_load_o, latch_load_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R0";
    bit    exp_up_q[$];
    string exp_tag_q[$];
    bit    m_e;
    string m_t;

    always #4 clk = ~clk;

    qdec_count_front dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .icr_wr       (icr_wr),
        .qr_wr        (qr_wr),
        .wr_data      (wr_data),
        .in_a         (in_a),
        .in_b         (in_b),
        .pin_dual_n   (pin_dual_n),
        .pin_load_n   (pin_load_n),
        .cnt_up_o     (cnt_up_o),
        .cnt_dn_o     (cnt_dn_o),
        .dir_up_o     (dir_up_o),
        .ctr_clear_o  (ctr_clear_o),
        .ctr_load_o   (ctr_load_o),
        .latch_load_o (latch_load_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_icr(input logic [5:0] d);
        @(negedge clk);
        wr_data = d;
        icr_wr  = 1'b1;
        @(negedge clk);
        icr_wr  = 1'b0;
    endtask

    task automatic write_qr(input logic [1:0] d);
        @(negedge clk);
        wr_data = {4'b0, d};
        qr_wr   = 1'b1;
        @(negedge clk);
        qr_wr   = 1'b0;
    endtask

    task automatic expect_ev(input bit up);
        exp_up_q.push_back(up);
        exp_tag_q.push_back(cur_tag);
    endtask

    // drive A,B; optionally announce the pulse it must cause
    task automatic set_ab(input logic a, input logic b, input bit has, input bit up);
        if (has) expect_ev(up);
        @(negedge clk);
        in_a = a;
        in_b = b;
        hold(12);
    endtask

    task automatic settle();
        hold(20);
        check(exp_up_q.size() == 0, {cur_tag, " missing pulses"}, exp_up_q.size(), 0);
        exp_up_q.delete();
        exp_tag_q.delete();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && (cnt_up_o || cnt_dn_o)) begin
            if (exp_up_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected pulse"}, {30'd0, cnt_up_o, cnt_dn_o}, 0);
            end else begin
                m_e = exp_up_q.pop_front();
                m_t = exp_tag_q.pop_front();
                check(cnt_up_o == m_e && cnt_dn_o == !m_e, {m_t, " pulse direction"},
                      {30'd0, cnt_up_o, cnt_dn_o}, m_e ? 2 : 1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(3);

        // reset state
        check(!cnt_up_o && !cnt_dn_o, "R9 reset pulses", {cnt_up_o, cnt_dn_o}, 0);
        check(dir_up_o == 1'b1, "R8 reset dir", dir_up_o, 1);
        check(!ctr_clear_o, "R10 reset clear", ctr_clear_o, 0);
        check(!ctr_load_o && !latch_load_o, "R11 reset load", {ctr_load_o, latch_load_o}, 0);

        // R9: inputs disabled
        cur_tag = "R9";
        set_ab(1, 0, 0, 0);
        set_ab(0, 1, 0, 0);
        set_ab(0, 0, 0, 0);
        settle();

        // R1: up clock / down clock
        cur_tag = "R1";
        write_icr(6'b001000);
        set_ab(1, 0, 1, 1);
        set_ab(0, 0, 0, 0);
        set_ab(0, 1, 1, 0);
        set_ab(0, 0, 0, 0);
        set_ab(1, 1, 0, 0);   // both rise together: cancel
        set_ab(0, 0, 0, 0);
        settle();

        // R2: clock plus direction
        cur_tag = "R2";
        write_icr(6'b001001);
        set_ab(1, 0, 1, 1);
        set_ab(0, 0, 0, 0);
        set_ab(0, 1, 0, 0);   // B edge alone: no count
        set_ab(1, 1, 1, 0);
        set_ab(0, 1, 0, 0);
        set_ab(0, 0, 0, 0);
        settle();

        // R12: software steps
        cur_tag = "R12";
        expect_ev(1);
        write_icr(6'b001010);
        settle();
        expect_ev(0);
        write_icr(6'b001100);
        settle();
        write_icr(6'b001110);
        settle();
        write_icr(6'b000010);
        settle();

        // R10: gate mode
        cur_tag = "R10";
        write_icr(6'b011000);
        hold(4);
        check(!ctr_clear_o, "R10 gate mode clear", ctr_clear_o, 0);
        set_ab(1, 0, 0, 0);   // gate closed
        set_ab(0, 0, 0, 0);
        settle();
        @(negedge clk);
        pin_dual_n = 1'b0;
        hold(4);
        check(!ctr_clear_o, "R10 gate low clear", ctr_clear_o, 0);
        set_ab(1, 0, 1, 1);   // gate open
        set_ab(0, 0, 0, 0);
        settle();
        pin_dual_n = 1'b1;
        write_icr(6'b001000);
        @(negedge clk);
        pin_dual_n = 1'b0;
        hold(4);
        check(ctr_clear_o == 1'b1, "R10 clear asserted", ctr_clear_o, 1);
        pin_dual_n = 1'b1;
        hold(4);
        check(!ctr_clear_o, "R10 clear released", ctr_clear_o, 0);

        // R11: load pin target
        cur_tag = "R11";
        pin_load_n = 1'b0;
        hold(4);
        check(ctr_load_o && !latch_load_o, "R11 counter load", {ctr_load_o, latch_load_o}, 2);
        write_icr(6'b101000);
        hold(2);
        check(!ctr_load_o && latch_load_o, "R11 latch load", {ctr_load_o, latch_load_o}, 1);
        pin_load_n = 1'b1;
        hold(4);
        check(!ctr_load_o && !latch_load_o, "R11 released", {ctr_load_o, latch_load_o}, 0);

        // R3: x4
        cur_tag = "R3";
        write_icr(6'b001000);
        write_qr(2'b11);
        set_ab(1, 0, 1, 1);
        set_ab(1, 1, 1, 1);
        set_ab(0, 1, 1, 1);
        set_ab(0, 0, 1, 1);
        settle();
        check(dir_up_o == 1'b1, "R8 dir after forward", dir_up_o, 1);
        set_ab(0, 1, 1, 0);
        set_ab(1, 1, 1, 0);
        set_ab(1, 0, 1, 0);
        set_ab(0, 0, 1, 0);
        settle();
        check(dir_up_o == 1'b0, "R8 dir after reverse", dir_up_o, 0);

        // R6: both inputs change together
        cur_tag = "R6";
        set_ab(1, 1, 0, 0);
        set_ab(0, 0, 0, 0);
        set_ab(1, 0, 1, 1);
        set_ab(0, 0, 1, 0);
        settle();

        // R7: filter window
        cur_tag = "R7";
        @(negedge clk);
        in_a = 1'b1;
        hold(2);
        in_a = 1'b0;
        settle();
        expect_ev(1);
        expect_ev(0);
        @(negedge clk);
        in_a = 1'b1;
        hold(6);
        in_a = 1'b0;
        settle();

        // R4: x2
        cur_tag = "R4";
        write_qr(2'b10);
        set_ab(1, 0, 1, 1);
        set_ab(1, 1, 0, 0);
        set_ab(0, 1, 1, 1);
        set_ab(0, 0, 0, 0);
        set_ab(0, 1, 0, 0);
        set_ab(1, 1, 1, 0);
        set_ab(1, 0, 0, 0);
        set_ab(0, 0, 1, 0);
        settle();

        // R5: x1
        cur_tag = "R5";
        write_qr(2'b01);
        set_ab(1, 0, 1, 1);
        set_ab(1, 1, 0, 0);
        set_ab(0, 1, 0, 0);
        set_ab(0, 0, 0, 0);
        set_ab(0, 1, 0, 0);
        set_ab(1, 1, 0, 0);
        set_ab(1, 0, 0, 0);
        set_ab(0, 0, 1, 0);
        settle();

        // R8: leaving quadrature forces up
        cur_tag = "R8";
        check(dir_up_o == 1'b0, "R8 dir before exit", dir_up_o, 0);
        write_qr(2'b00);
        hold(2);
        check(dir_up_o == 1'b1, "R8 dir forced", dir_up_o, 1);

        finish_run();
    end

endmodule